// File: doc/BRIEF.md
# Converter Startup and Shutdown Sequencer

This block orders the bring-up and shut-down of a single-phase step-down converter. It watches a pair of supply comparators, the done flag of the overcurrent threshold setting phase, a disable request taken from the compensation node being pulled low, a comparator that reports feedback at the reference, a flag for each high-side gate pulse, a comparator that reports the output above target, and the latched overcurrent flag. From these it drives four registered enables: soft-start current, error-amplifier output, high-side driver and low-side driver.

The controller holds the drivers idle through supply lockout and threshold setting. It then runs a soft-start ramp and hands over to the closed loop once feedback reaches the reference. During the ramp the low-side switch stays off until the high side has switched once. This protects a pre-charged output from being pulled down. If the output already sits above target, the low side is released so that it can discharge the output. A disable request idles both switches but keeps the soft-start current flowing, and its release starts a fresh ramp. A latched overcurrent idles everything until the supply drops out.

Top module: `startup_seq`

## Requirements
- R1: After the supply passes the upper threshold, the block sits in threshold setting with all four enables low. On the clock edge after `thr_done` is seen high, `ss_en` and `hs_en` go high while `ea_en` and `ls_en` stay low.
- R2: During the ramp, `fb_at_ref` high moves the block to regulation on the next edge: `ss_en`=0, `ea_en`=1, `hs_en`=1, `ls_en`=1. Regulation is held after `fb_at_ref` falls.
- R3: During a ramp, `ls_en` stays low until a cycle with `hs_pulse` high. From the following edge it stays high for the rest of that ramp.
- R4: During a ramp in which no high-side pulse has been seen, `ls_en` follows `over_target`, one edge later.
- R5: `dis_req` passes through a two-flop synchronizer and acts on the third rising edge after it changes. In ramp or regulation it gives `ss_en`=1 with the other three enables low. On release the block starts a new ramp (`ss_en`=1, `hs_en`=1, `ea_en`=0, `ls_en`=0), and any high-side pulse seen before the disable is forgotten.
- R6: Supply hysteresis uses two levels. Leaving lockout needs `vcc_above_on`. After that, `vcc_above_off` alone keeps the block running. With `vcc_above_off` low, all enables are low on the next edge and the block returns to lockout.
- R7: With the supply up, `ocp_latched` high makes all enables low on the next edge. They stay low after `ocp_latched` clears, whatever the other inputs do, until the supply drops below the lower level.
- R8: Synchronous active-high `rst` puts the block in lockout with all four enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_above_on | input | 1 | Supply above the turn-on level |
| vcc_above_off | input | 1 | Supply above the turn-off level |
| thr_done | input | 1 | Overcurrent threshold setting finished |
| dis_req | input | 1 | Asynchronous disable request (compensation node held low) |
| fb_at_ref | input | 1 | Feedback has reached the reference |
| hs_pulse | input | 1 | A high-side gate pulse occurred this cycle |
| over_target | input | 1 | Output is above its regulation target |
| ocp_latched | input | 1 | Latched overcurrent fault |
| ss_en | output | 1 | Soft-start current enable |
| ea_en | output | 1 | Error-amplifier output enable |
| hs_en | output | 1 | High-side driver enable |
| ls_en | output | 1 | Low-side driver enable |

## Verification
The bench targets the pre-bias rule. A design that enabled the low side at ramp start would discharge a pre-charged output, and one that did not clear its pulse memory after a disable would skip that protection on the restart. It also probes the supply hysteresis band, where a design that checked only the upper level would drop out in mid-ramp. It counts the disable latency edge by edge, so a missing or extra synchronizer stage is caught. Finally, it clears the overcurrent input after a trip, where a non-latching design would resume switching.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    ST_LOCK  = 3'd0,
    ST_THR   = 3'd1,
    ST_RAMP  = 3'd2,
    ST_REG   = 3'd3,
    ST_DIS   = 3'd4,
    ST_FAULT = 3'd5
  } seq_state_t;
endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[LAST-1:0], d};
  end

  assign q = chain[LAST];
endmodule

// File: rtl/seq_prebias.sv
module seq_prebias
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_t cur,
  input  seq_state_t nxt,
  input  logic       hs_pulse,
  input  logic       over_target,
  output logic       ls_allow
);
  logic hs_seen, hs_seen_nxt;

  // Memory of a high-side pulse lives only within one continuous ramp
  always_comb begin
    if (cur == ST_RAMP && nxt == ST_RAMP) hs_seen_nxt = hs_seen | hs_pulse;
    else                                  hs_seen_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) hs_seen <= 1'b0;
    else     hs_seen <= hs_seen_nxt;
  end

  assign ls_allow = hs_seen_nxt | over_target;

  // R3: once a pulse is remembered, it holds while the ramp continues
  assert_seen_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (hs_seen && cur == ST_RAMP && nxt == ST_RAMP) |-> ls_allow);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       vcc_above_on,
  input  logic       vcc_above_off,
  input  logic       thr_done,
  input  logic       dis_s,
  input  logic       fb_at_ref,
  input  logic       ocp_latched,
  input  logic       ls_allow,
  output seq_state_t state,
  output seq_state_t nxt,
  output logic       ss_en,
  output logic       ea_en,
  output logic       hs_en,
  output logic       ls_en
);
  always_comb begin
    nxt = state;
    if (!vcc_above_off)   nxt = ST_LOCK;
    else if (ocp_latched) nxt = ST_FAULT;
    else begin
      case (state)
        ST_LOCK:  if (vcc_above_on) nxt = ST_THR;
        ST_THR:   if (thr_done)     nxt = ST_RAMP;
        ST_RAMP:  if (dis_s)        nxt = ST_DIS;
                  else if (fb_at_ref) nxt = ST_REG;
        ST_REG:   if (dis_s)        nxt = ST_DIS;
        ST_DIS:   if (!dis_s)       nxt = ST_RAMP;
        ST_FAULT: nxt = ST_FAULT;
        default:  nxt = ST_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_LOCK;
      ss_en <= 1'b0;
      ea_en <= 1'b0;
      hs_en <= 1'b0;
      ls_en <= 1'b0;
    end else begin
      state <= nxt;
      ss_en <= (nxt == ST_RAMP) || (nxt == ST_DIS);
      ea_en <= (nxt == ST_REG);
      hs_en <= (nxt == ST_RAMP) || (nxt == ST_REG);
      ls_en <= (nxt == ST_REG) || ((nxt == ST_RAMP) && ls_allow);
    end
  end

  assert_ramp_after_setup_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(ss_en) |-> $past(thr_done && vcc_above_off));

  assert_loop_on_ref_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ea_en) |-> $past(fb_at_ref));

  assert_disable_idles_R5: assert property (@(posedge clk) disable iff (rst)
    (dis_s && vcc_above_off && !ocp_latched && (state == ST_RAMP || state == ST_REG))
    |=> (!hs_en && !ls_en && ss_en));

  assert_undervolt_off_R6: assert property (@(posedge clk) disable iff (rst)
    !vcc_above_off |=> (!hs_en && !ls_en && !ss_en && !ea_en));

  assert_fault_off_R7: assert property (@(posedge clk) disable iff (rst)
    (ocp_latched && vcc_above_off) |=> (!hs_en && !ls_en && !ss_en && !ea_en));

  assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FAULT && vcc_above_off) |=> (state == ST_FAULT));
endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic vcc_above_on,
  input  logic vcc_above_off,
  input  logic thr_done,
  input  logic dis_req,
  input  logic fb_at_ref,
  input  logic hs_pulse,
  input  logic over_target,
  input  logic ocp_latched,
  output logic ss_en,
  output logic ea_en,
  output logic hs_en,
  output logic ls_en
);
  logic       dis_s;
  logic       ls_allow;
  seq_state_t state, nxt;

  seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(dis_req), .q(dis_s)
  );

  seq_prebias u_prebias (
    .clk(clk), .rst(rst), .cur(state), .nxt(nxt),
    .hs_pulse(hs_pulse), .over_target(over_target), .ls_allow(ls_allow)
  );

  seq_fsm u_fsm (
    .clk(clk), .rst(rst),
    .vcc_above_on(vcc_above_on), .vcc_above_off(vcc_above_off),
    .thr_done(thr_done), .dis_s(dis_s), .fb_at_ref(fb_at_ref),
    .ocp_latched(ocp_latched), .ls_allow(ls_allow),
    .state(state), .nxt(nxt),
    .ss_en(ss_en), .ea_en(ea_en), .hs_en(hs_en), .ls_en(ls_en)
  );

  // R3: without a pulse or over-target, an idle low side stays idle in the ramp
  assert_ls_waits_R3: assert property (@(posedge clk) disable iff (rst)
    (ss_en && hs_en && !ea_en && !ls_en && !hs_pulse && !over_target &&
     !fb_at_ref && !dis_s && vcc_above_off && !ocp_latched) |=> !ls_en);

  // R4: over-target in a running ramp releases the low side
  assert_discharge_R4: assert property (@(posedge clk) disable iff (rst)
    (ss_en && hs_en && over_target && !fb_at_ref && !dis_s &&
     vcc_above_off && !ocp_latched) |=> ls_en);
endmodule

// File: tb/startup_seq_bench.sv
`timescale 1ns/100ps
module startup_seq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vcc_above_on = 0, vcc_above_off = 0, thr_done = 0, dis_req = 0;
  logic fb_at_ref = 0, hs_pulse = 0, over_target = 0, ocp_latched = 0;
  logic ss_en, ea_en, hs_en, ls_en;
  int   errors = 0;
  int   checks = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  startup_seq u_startup_seq (
    .clk(clk), .rst(rst), .vcc_above_on(vcc_above_on), .vcc_above_off(vcc_above_off),
    .thr_done(thr_done), .dis_req(dis_req), .fb_at_ref(fb_at_ref), .hs_pulse(hs_pulse),
    .over_target(over_target), .ocp_latched(ocp_latched),
    .ss_en(ss_en), .ea_en(ea_en), .hs_en(hs_en), .ls_en(ls_en)
  );

  // {req[3:0], on, off, thr, fb, hsp, ovr, ocp, exp ss, ea, hs, ls}
  localparam int NVEC = 19;
  localparam logic [14:0] VEC [NVEC] = '{
    {4'd8, 7'b0000000, 4'b0000},  // R8 lockout after reset
    {4'd6, 7'b0100000, 4'b0000},  // R6 lower level alone does not start
    {4'd1, 7'b1100000, 4'b0000},  // R1 threshold setting
    {4'd1, 7'b1100000, 4'b0000},  // R1 waits for thr_done
    {4'd1, 7'b1110000, 4'b1010},  // R1 ramp begins, low side idle
    {4'd6, 7'b0110000, 4'b1010},  // R6 inside hysteresis band keeps running
    {4'd3, 7'b0110100, 4'b1011},  // R3 first high-side pulse
    {4'd3, 7'b0110000, 4'b1011},  // R3 remembered
    {4'd2, 7'b0111000, 4'b0111},  // R2 regulation
    {4'd2, 7'b0110000, 4'b0111},  // R2 held
    {4'd6, 7'b0000000, 4'b0000},  // R6 drop-out
    {4'd6, 7'b1100000, 4'b0000},  // R6 restart to threshold setting
    {4'd1, 7'b1110000, 4'b1010},  // R1 fresh ramp
    {4'd4, 7'b1110010, 4'b1011},  // R4 over target discharges
    {4'd4, 7'b1110000, 4'b1010},  // R4 back to idle low side
    {4'd7, 7'b1110001, 4'b0000},  // R7 fault
    {4'd7, 7'b1110000, 4'b0000},  // R7 latched after clear
    {4'd7, 7'b1111100, 4'b0000},  // R7 ignores other inputs
    {4'd6, 7'b0000000, 4'b0000}   // R6 supply cycle
  };

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {ss_en, ea_en, hs_en, ls_en};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: enables ss/ea/hs/ls actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R8", 4'b0000);
    @(negedge clk) rst = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      {vcc_above_on, vcc_above_off, thr_done, fb_at_ref, hs_pulse, over_target, ocp_latched}
        = VEC[v][10:4];
      step(1);
      check($sformatf("R%0d vec%0d", VEC[v][14:11], v), VEC[v][3:0]);
    end

    // Bring up to regulation, then disable (R5)
    @(negedge clk) {vcc_above_on, vcc_above_off} = 2'b11; step(1);
    @(negedge clk) thr_done = 1; step(1);
    @(negedge clk) fb_at_ref = 1; step(1);
    check("R2 directed", 4'b0111);
    @(negedge clk) begin fb_at_ref = 0; dis_req = 1; end
    step(2);
    check("R5 sync latency", 4'b0111);
    step(1);
    check("R5 disabled", 4'b1000);
    @(negedge clk) hs_pulse = 1; step(1);
    check("R5 held disabled", 4'b1000);
    @(negedge clk) begin hs_pulse = 0; dis_req = 0; end
    step(2);
    check("R5 release latency", 4'b1000);
    step(1);
    check("R5 fresh ramp", 4'b1010);
    step(1);
    check("R3 restart waits", 4'b1010);
    @(negedge clk) hs_pulse = 1; step(1);
    check("R3 after restart", 4'b1011);
    @(negedge clk) begin hs_pulse = 0; rst = 1; end
    step(1);
    check("R8 mid-run reset", 4'b0000);
    @(negedge clk) rst = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule